// File: doc/BRIEF.md
# Reload Timer Carrier Generator with Output Modulation

The block is a down-counting reload timer running on the system clock. Once enabled, it counts down from a programmed reload value. Each time it wraps, it reloads, raises a one-cycle interrupt request and flips a square-wave carrier. The carrier therefore runs at the system clock divided by twice the reload value.

Next to the timer sits an output stage for an 8-bit port. Each pin either passes its data bit straight through or gates the carrier onto the pin. The polarity of that gating depends on whether the pin number is even or odd. While any pin has modulation selected, the timer interrupt is withheld, so the timer can serve as a dedicated carrier source.

Software programs the block through a small write-only register bus. Address 0 holds the reload value, address 1 bit 0 is the timer enable, and address 2 holds the per-pin modulation select. Address 3 is unused.

Top module: `carrier_timer`

## Requirements
- R1: After reset, the enable and modulation-select registers are zero, the reload register holds 0xFF, `irq` is 0, and `pin_out` equals `port_data`.
- R2: A write of 1 to address 1 bit 0 enables the timer. If the write lands on clock edge E, `irq` is high for exactly one cycle after edge E+N, where N is the reload value. It repeats every N cycles after that.
- R3: The carrier changes level at every reload. It is low when the timer is first enabled, so it first goes high after edge E+N and stays at each level for N cycles.
- R4: A reload write of 0 to address 0 is stored as 1. The timer then reloads on every clock, and `irq` is high in every cycle.
- R5: A pin whose modulation-select bit (address 2, bit i) is 0 outputs its `port_data` bit unchanged.
- R6: A modulated even-numbered pin outputs the carrier while its data bit is 1, and outputs 0 while its data bit is 0.
- R7: A modulated odd-numbered pin outputs the carrier while its data bit is 0, and outputs 0 while its data bit is 1.
- R8: While any modulation-select bit is 1, `irq` stays 0, even though the timer keeps reloading.
- R9: While the timer is disabled, the carrier is low and the counter holds the reload value. After re-enabling, the first `irq` therefore comes a full N cycles after the enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 reload, 1 control, 2 modulation select |
| wr_data | input | 8 | Register write data |
| port_data | input | 8 | Data bits for the port pins |
| irq | output | 1 | Timer interrupt request, one cycle per reload |
| pin_out | output | 8 | Buffered or carrier-modulated pin values |

## Verification
The assertions assume that the bus never places a zero in the counter, and that the enable and reload values change only through registered writes. Under those assumptions, the counter always sits between 1 and the reload value. The stimulus writes one register at a time on a quiet cycle and changes `port_data` only between samples. Modulation patterns are checked only inside a carrier window whose phase follows from the enable edge: a long reload is used so that the carrier is known to be high while the patterns are applied.

// File: rtl/carrier_timer_pkg.sv
package carrier_timer_pkg;

    typedef enum logic [1:0] {
        ADDR_RELOAD = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_MODSEL = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic tick;
        logic carrier;
    } timer_evt_t;

    // Pins with an even index call for the carrier on data 1, odd on data 0.
    function automatic logic carrier_wanted(input logic data_bit, input logic odd_pin);
        return data_bit ^ odd_pin;
    endfunction

endpackage

// File: rtl/carrier_timer_regs.sv
module carrier_timer_regs
    import carrier_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] reload,
    output logic              enable,
    output logic [DATA_W-1:0] modsel
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    reg_addr_e sel;
    assign sel = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '1;
            enable <= 1'b0;
            modsel <= '0;
        end else if (wr_en) begin
            case (sel)
                ADDR_RELOAD: reload <= (wr_data == '0) ? ONE : wr_data;
                ADDR_CTRL:   enable <= wr_data[0];
                ADDR_MODSEL: modsel <= wr_data;
                default:     ;
            endcase
        end
    end

    assert_reload_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        reload != '0);
endmodule

// File: rtl/carrier_timer_core.sv
module carrier_timer_core
    import carrier_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] reload,
    output timer_evt_t       evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '1;
            evt.carrier <= 1'b0;
            evt.tick    <= 1'b0;
        end else if (!enable) begin
            cnt         <= reload;
            evt.carrier <= 1'b0;
            evt.tick    <= 1'b0;
        end else if (cnt <= ONE) begin
            cnt         <= reload;
            evt.carrier <= ~evt.carrier;
            evt.tick    <= 1'b1;
        end else begin
            cnt         <= cnt - ONE;
            evt.tick    <= 1'b0;
        end
    end

    assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);
    assert_idle_carrier_low_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !evt.carrier && !evt.tick);
    assert_tick_flips_carrier_R3: assert property (@(posedge clk) disable iff (rst)
        evt.tick |-> (evt.carrier != $past(evt.carrier)) && $past(enable));
    assert_idle_holds_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable && $stable(reload)) |=> cnt == $past(reload));
endmodule

// File: rtl/carrier_timer_outmod.sv
module carrier_timer_outmod
    import carrier_timer_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] port_data,
    input  logic [PORT_W-1:0] modsel,
    input  logic              carrier,
    output logic [PORT_W-1:0] pin_out
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        localparam logic ODD = (i % 2) == 1;
        always_comb begin
            if (modsel[i]) pin_out[i] = carrier & carrier_wanted(port_data[i], ODD);
            else           pin_out[i] = port_data[i];
        end
    end

    always_comb begin
        assert_plain_pins_R5: assert ((pin_out & ~modsel) == (port_data & ~modsel));
    end
endmodule

// File: rtl/carrier_timer.sv
module carrier_timer
    import carrier_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] port_data,
    output logic              irq,
    output logic [DATA_W-1:0] pin_out
);
    localparam int CNT_W  = DATA_W;
    localparam int PORT_W = DATA_W;

    logic [CNT_W-1:0]  reload;
    logic              enable;
    logic [PORT_W-1:0] modsel;
    timer_evt_t        evt;

    carrier_timer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reload(reload), .enable(enable), .modsel(modsel)
    );

    carrier_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .enable(enable), .reload(reload), .evt(evt)
    );

    carrier_timer_outmod #(.PORT_W(PORT_W)) u_outmod (
        .port_data(port_data), .modsel(modsel), .carrier(evt.carrier), .pin_out(pin_out)
    );

    assign irq = evt.tick & ~(|modsel);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (|modsel) |-> !irq);
    assert_gated_low_R6: assert property (@(posedge clk) disable iff (rst)
        !evt.carrier |-> ((pin_out & modsel) == '0));
    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(enable));
endmodule

// File: tb/test_carrier_timer.sv
module test_carrier_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] port_data = 8'd0;
    logic       irq;
    logic [7:0] pin_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    carrier_timer i_carrier_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .port_data(port_data), .irq(irq), .pin_out(pin_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] model_pins(input logic [7:0] d, input logic [7:0] s, input logic c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (!s[i]) r[i] = d[i];
            else if (i % 2 == 0) r[i] = c & d[i];
            else r[i] = c & ~d[i];
        end
        return r;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset_R1();
        port_data = 8'h5A;
        do_reset();
        #1;
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(pin_out == 8'h5A, "R1 pins", pin_out, 8'h5A);
        repeat (300) @(negedge clk);
        chk(irq == 1'b0, "R1 idle irq", irq, 0);
    endtask

    task automatic test_period_R2(input logic [7:0] n);
        do_reset();
        port_data = 8'h00;
        wr(2'd0, n);
        wr(2'd1, 8'h01);
        for (int k = 1; k <= 3 * n + 1; k++) begin
            @(negedge clk);
            chk(irq == ((k % n) == 0), "R2 irq timing", irq, (k % n) == 0);
        end
        wr(2'd1, 8'h00);
    endtask

    task automatic test_zero_R4();
        do_reset();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk(irq == 1'b1, "R4 zero acts as one", irq, 1);
        end
        wr(2'd1, 8'h00);
    endtask

    task automatic test_carrier_R3_R8();
        do_reset();
        port_data = 8'h01;
        wr(2'd2, 8'h01);
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h01);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk(pin_out[0] == (((k / 3) % 2) == 1), "R3 carrier level", pin_out[0], ((k / 3) % 2) == 1);
            chk(irq == 1'b0, "R8 irq masked", irq, 0);
        end
        wr(2'd1, 8'h00);
    endtask

    task automatic test_unmask_R8();
        do_reset();
        wr(2'd0, 8'd4);
        wr(2'd2, 8'h80);
        wr(2'd1, 8'h01);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk(irq == 1'b0, "R8 single select bit masks", irq, 0);
        end
        wr(2'd2, 8'h00);
        // sel cleared two negedges after the previous window end (k=10 now)
        for (int k = 11; k <= 17; k++) begin
            @(negedge clk);
            chk(irq == ((k % 4) == 0), "R8 unmasked irq", irq, (k % 4) == 0);
        end
        wr(2'd1, 8'h00);
    endtask

    task automatic test_modulation_R5_R6_R7();
        logic [7:0] pats [4] = '{8'hAA, 8'h55, 8'h0F, 8'hC3};
        do_reset();
        wr(2'd2, 8'hFF);
        port_data = 8'h55;
        @(negedge clk);
        chk(pin_out == 8'h00, "R9 disabled carrier low", pin_out, 0);
        wr(2'd0, 8'd200);
        wr(2'd1, 8'h01);
        repeat (200) @(negedge clk);
        foreach (pats[j]) begin
            port_data = pats[j];
            #1;
            chk(pin_out == model_pins(pats[j], 8'hFF, 1'b1), "R6 R7 modulated pattern",
                pin_out, model_pins(pats[j], 8'hFF, 1'b1));
            @(negedge clk);
        end
        port_data = 8'h0F; #1;
        chk(pin_out == 8'hA5, "R6 R7 fixed 0F pattern", pin_out, 8'hA5);
        wr(2'd2, 8'hF0);
        port_data = 8'h3C; #1;
        chk(pin_out == 8'h9C, "R5 mixed select", pin_out, 8'h9C);
        wr(2'd2, 8'h00);
        port_data = 8'hA7; #1;
        chk(pin_out == 8'hA7, "R5 plain buffer", pin_out, 8'hA7);
        wr(2'd1, 8'h00);
    endtask

    task automatic test_hold_R9();
        do_reset();
        wr(2'd0, 8'd7);
        wr(2'd1, 8'h01);
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h00);
        repeat (5) @(negedge clk);
        chk(irq == 1'b0, "R9 disabled irq", irq, 0);
        wr(2'd1, 8'h01);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            chk(irq == (k == 7), "R9 full period after re-enable", irq, k == 7);
        end
        wr(2'd1, 8'h00);
    endtask

    initial begin
        test_reset_R1();
        test_period_R2(8'd5);
        test_period_R2(8'd1);
        test_zero_R4();
        test_carrier_R3_R8();
        test_unmask_R8();
        test_modulation_R5_R6_R7();
        test_hold_R9();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule